// File: doc/BRIEF.md
# Programmable Baud Divider with Receive Clock Selection

This block is the rate source for one asynchronous serial channel. It divides the system clock by a 16-bit value that software loads one byte at a time into two divisor latches. The result is a single-cycle strobe at sixteen times the serial bit rate. A second counter divides that strobe by sixteen and gives the transmitter a bit-rate strobe.

The receiver takes its reference from one of two sources, chosen by a static strap. With the strap high, it shares the internal divider. With the strap low, it follows an external receive clock pin instead. That pin passes through a two-flop synchronizer, and each rising edge becomes a one-cycle enable. The receiver has its own divide-by-sixteen counter, which gives it a bit-rate strobe of its own. The shift registers, FIFOs and bus logic of the channel live outside this block.

Top module: `baud_divgen`

## Requirements
- R1: The divisor is {high latch, low latch}. A write with `wr_sel`=0 loads the low byte and a write with `wr_sel`=1 loads the high byte. For a divisor D of 1 or more, `baud_stb` pulses for one cycle every D system clock cycles.
- R2: While the divisor is zero, `baud_stb`, `tx_bit_stb` and, with the strap high, `rx_tick16` and `rx_bit_stb` stay low.
- R3: With a divisor of one, `baud_stb` is high in every cycle.
- R4: A write to either latch restarts the count. With the write captured at clock edge k, the first `baud_stb` appears in the D-th cycle after edge k, and further strobes follow every D cycles.
- R5: `tx_bit_stb` pulses together with every sixteenth `baud_stb`, counted from the last latch write, so the first one comes 16·D cycles after that write.
- R6: With `rx_int_sel` high, `rx_tick16` equals `baud_stb` and `rx_bit_stb` equals `tx_bit_stb` in every cycle.
- R7: With `rx_int_sel` low, `rx_tick16` pulses for exactly one cycle for each rising edge of `rx_clk_ext`. The pulse comes two clock cycles after the edge is first sampled, and the internal baud strobes do not reach the receive side.
- R8: `rx_bit_stb` pulses together with every sixteenth `rx_tick16` after reset.
- R9: After reset both latches are zero and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 1 | Latch select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Byte to write |
| rx_int_sel | input | 1 | Strap: 1 receiver uses internal divider, 0 uses external pin |
| rx_clk_ext | input | 1 | External receive clock (asynchronous) |
| baud_stb | output | 1 | 16x-rate strobe from the divider (transmit oversample enable) |
| tx_bit_stb | output | 1 | Transmit bit-rate strobe |
| rx_tick16 | output | 1 | Receive 16x-rate enable |
| rx_bit_stb | output | 1 | Receive bit-rate strobe |

## Verification
The bench uses the default 16-bit divisor, 16x oversampling and two synchronizer stages. It sweeps every divisor from 1 to 40 over a full bit period and compares each cycle against the residue arithmetic i mod D and i mod 16·D. This covers restart phase, divide-by-one and the bit-strobe alignment in every case. Divisors that need the high latch (255, 256, 257, 0x1234) check that the two bytes are joined in the right order. A zero divisor and an external clock run with the strap low cover the silent state and the selection of the receive source.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
  // Join byte lanes into the divisor value (lane 0 is least significant).
  function automatic logic [15:0] bdg_join(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

  // True when the counter sits at the last step of a period of length div.
  function automatic logic bdg_at_end(input logic [15:0] cnt, input logic [15:0] div);
    return (div != 16'd0) && (cnt == div - 16'd1);
  endfunction
endpackage

// File: rtl/bdg_divider.sv
module bdg_divider #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_val,
  output logic [DIV_W-1:0] cnt_val,
  output logic             stb
);
  import bdg_pkg::*;
  localparam int LANES = DIV_W / BYTE_W;

  logic [BYTE_W-1:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q[g] <= '0;
      else if (wr_en && (int'(wr_sel) == g))
        lane_q[g] <= wr_data;
    end
  end

  assign div_val = bdg_join(lane_q[0], lane_q[LANES-1]);
  assign stb     = bdg_at_end(cnt_val, div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_val <= '0;
    else if (wr_en || div_val == '0 || stb)
      cnt_val <= '0;
    else
      cnt_val <= cnt_val + 1'b1;
  end
endmodule

// File: rtl/bdg_bitdiv.sv
module bdg_bitdiv #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic bit_stb
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q;

  assign bit_stb = tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/bdg_edge_sync.sv
module bdg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= '0;
    else
      sr_q <= {sr_q[STAGES-1:0], din};
  end

  assign rise = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/baud_divgen.sv
module baud_divgen #(
  parameter int DIV_W       = 16,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rx_int_sel,
  input  logic       rx_clk_ext,
  output logic       baud_stb,
  output logic       tx_bit_stb,
  output logic       rx_tick16,
  output logic       rx_bit_stb
);
  logic [DIV_W-1:0] div_val;
  logic [DIV_W-1:0] cnt_val;
  logic             ext_rise;
  logic             rx_clr;

  bdg_divider #(.DIV_W(DIV_W), .BYTE_W(8)) u_div (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .div_val(div_val), .cnt_val(cnt_val), .stb(baud_stb)
  );

  bdg_bitdiv #(.OVS(OVS)) u_txbit (
    .clk(clk), .rst_n(rst_n), .clr(wr_en), .tick(baud_stb), .bit_stb(tx_bit_stb)
  );

  bdg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_clk_ext), .rise(ext_rise)
  );

  assign rx_tick16 = rx_int_sel ? baud_stb : ext_rise;
  assign rx_clr    = rx_int_sel & wr_en;

  bdg_bitdiv #(.OVS(OVS)) u_rxbit (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .tick(rx_tick16), .bit_stb(rx_bit_stb)
  );
endmodule

// File: rtl/bdg_checks.sv
module bdg_checks #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rx_int_sel,
  input logic [DIV_W-1:0] div_val,
  input logic             baud_stb,
  input logic             tx_bit_stb,
  input logic             rx_tick16,
  input logic             rx_bit_stb
);
  // R2: zero divisor keeps the divider silent
  a_r2_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) |-> (!baud_stb && !tx_bit_stb));

  // R3: divide-by-one strobes every cycle
  a_r3_div_one: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == DIV_W'(1)) |-> baud_stb);

  // R4: a write restarts the count at phase zero
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && div_val != DIV_W'(1)) |-> !baud_stb);

  // R5: the bit strobe only coincides with a baud strobe
  a_r5_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_stb |-> baud_stb);

  // R6: internal selection mirrors the divider
  a_r6_internal_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int_sel |-> (rx_tick16 == baud_stb && rx_bit_stb == tx_bit_stb));

  // R7: external ticks last one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_int_sel && rx_tick16) |=> !rx_tick16);

  // R8: receive bit strobe only with a receive tick
  a_r8_rx_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_stb |-> rx_tick16);
endmodule

bind baud_divgen bdg_checks #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rx_int_sel(rx_int_sel),
  .div_val(div_val), .baud_stb(baud_stb), .tx_bit_stb(tx_bit_stb),
  .rx_tick16(rx_tick16), .rx_bit_stb(rx_bit_stb)
);

// File: tb/baud_divgen_test.sv
module baud_divgen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic rx_int_sel = 1'b1;
  logic rx_clk_ext = 1'b0;
  logic baud_stb, tx_bit_stb, rx_tick16, rx_bit_stb;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  baud_divgen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rx_int_sel(rx_int_sel), .rx_clk_ext(rx_clk_ext),
    .baud_stb(baud_stb), .tx_bit_stb(tx_bit_stb),
    .rx_tick16(rx_tick16), .rx_bit_stb(rx_bit_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_div(input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'(d & 8'hFF);
    @(negedge clk);
    wr_sel = 1'b1; wr_data = 8'((d >> 8) & 8'hFF);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Sweep cycles 1..win after the second write edge (current negedge is cycle 1).
  task automatic sweep(input int d, input int win);
    int bad_b = 0, bad_t = 0, bad_r = 0, first = 0;
    for (int i = 1; i <= win; i++) begin
      bit eb = (i % d) == 0;
      bit et = (i % (16 * d)) == 0;
      if (i > 1) @(negedge clk);
      if (baud_stb && first == 0) first = i;
      if (baud_stb !== eb) bad_b++;
      if (tx_bit_stb !== et) bad_t++;
      if (rx_tick16 !== baud_stb || rx_bit_stb !== tx_bit_stb) bad_r++;
    end
    check(first == d, "R4 first strobe cycle", first, d);
    check(bad_b == 0, (d == 1) ? "R3 divide-by-one pattern" : "R1 baud period", bad_b, 0);
    check(bad_t == 0, "R5 tx bit strobe", bad_t, 0);
    check(bad_r == 0, "R6 internal rx follows divider", bad_r, 0);
  endtask

  initial begin
    int cnt_b, cnt_t, cnt_r, cnt_rb;
    do_reset();
    // R9: reset state
    cnt_b = 0; cnt_r = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (baud_stb || tx_bit_stb) cnt_b++;
      if (rx_tick16 || rx_bit_stb) cnt_r++;
    end
    check(cnt_b == 0, "R9 no tx strobes after reset", cnt_b, 0);
    check(cnt_r == 0, "R9 no rx strobes after reset", cnt_r, 0);

    // R1..R6: exhaustive sweep of small divisors
    for (int d = 1; d <= 40; d++) begin
      write_div(d);
      sweep(d, 17 * d);
    end
    // R1: divisors using the high byte
    write_div(255);  sweep(255, 600);
    write_div(256);  sweep(256, 600);
    write_div(257);  sweep(257, 600);
    write_div(16'h1234); sweep(16'h1234, 2 * 16'h1234 + 5);
    // Restart mid-period with a short divisor
    write_div(3); repeat (2) @(negedge clk);
    write_div(5); sweep(5, 170);

    // R2: zero divisor
    write_div(0);
    cnt_b = 0;
    for (int i = 0; i < 300; i++) begin
      if (i > 0) @(negedge clk);
      if (baud_stb || tx_bit_stb || rx_tick16 || rx_bit_stb) cnt_b++;
    end
    check(cnt_b == 0, "R2 zero divisor silent", cnt_b, 0);

    // R7/R8: external receive clock with divider running
    rx_int_sel = 1'b0;
    do_reset();
    write_div(3);
    cnt_b = 0; cnt_t = 0; cnt_r = 0; cnt_rb = 0;
    for (int e = 0; e < 40; e++) begin
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        rx_clk_ext = (p < 4);
        if (baud_stb) cnt_b++;
        if (rx_tick16) cnt_r++;
        if (rx_bit_stb) cnt_rb++;
      end
    end
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      if (rx_tick16) cnt_r++;
      if (rx_bit_stb) cnt_rb++;
    end
    check(cnt_b > 40, "R7 divider active meanwhile", cnt_b, 106);
    check(cnt_r == 40, "R7 one tick per external rise", cnt_r, 40);
    check(cnt_rb == 2, "R8 rx bit strobe every 16 ticks", cnt_rb, 2);

    // R7: latency of one edge
    rx_clk_ext = 1'b0;
    repeat (4) @(negedge clk);
    rx_clk_ext = 1'b1;
    cnt_t = 0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (rx_tick16 && cnt_t == 0) cnt_t = i;
    end
    check(cnt_t == 2, "R7 tick latency", cnt_t, 2);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule